// File: doc/BRIEF.md
# Daisy-Chain Interrupt Acknowledge Chain

This block connects a fixed number of interrupt-capable device slots in series, ordered by priority, with slot 0 the most urgent. Each slot latches requests from its device. Every slot holding a pending request pulls down a shared active-low request line toward the processor. The line is modelled as a wired-AND of open-drain pulls.

When the processor raises its acknowledge, the acknowledge enters slot 0 as that slot's priority-in. It then ripples down the chain: each slot's priority-out feeds the priority-in of the next slot. The first slot that holds a request stops the ripple and places its own vector on a shared vector bus. The set of slots that may answer is frozen when the acknowledge rises. When the acknowledge falls, the served slot drops its request and the request line goes high again once no request is left.

Top module: `irq_daisy_chain`

## Requirements
- R1: Slot i owns the vector VEC_BASE + i*VEC_STRIDE. With the defaults (0x20, stride 4, four slots) these are 0x20, 0x24, 0x28 and 0x2C. A slot's vector appears on `vec_o` only when that slot holds the grant.
- R2: `irq_n_o` is 0 whenever at least one slot has a pending request, and 1 when no slot has one.
- R3: A slot becomes pending at any clock edge where its bit of `dev_req_i` is 1. It stays pending until it is served, whatever `dev_req_i` does afterwards.
- R4: While the acknowledge is active, the lowest-index slot that was pending at the acknowledge's rise holds the grant. `vec_o` then carries that slot's vector and `vec_valid_o` is 1. At most one slot is ever granted.
- R5: While the acknowledge is active, `chain_po_o[i]` is 1 for every slot above the winner and 0 for the winner and every slot below it.
- R6: If the acknowledge is active and no slot was pending at its rise, every bit of `chain_po_o` is 1, `vec_o` is 0 and `vec_valid_o` is 0.
- R7: While the acknowledge is inactive, `chain_po_o` is all zeros, `vec_o` is 0 and `vec_valid_o` is 0.
- R8: The pending set is sampled at the clock edge where `ack_i` is first seen high. A request that arrives later during the same acknowledge becomes pending but does not change the winner.
- R9: At the clock edge where `ack_i` is first seen low again, the winner's pending flag clears and all other slots keep theirs. If the winner's `dev_req_i` bit is 1 at that same edge, the new request wins and the slot stays pending.
- R10: The grant outputs respond one clock after `ack_i` is driven high. Before that first edge, `vec_valid_o` is still 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dev_req_i | input | NUM_SLOTS | Device request per slot, level, bit 0 is highest priority |
| ack_i | input | 1 | Processor acknowledge, active high, drives slot 0 priority-in |
| irq_n_o | output | 1 | Shared request line, active low, wired-AND of slot pulls |
| vec_o | output | VEC_W | Shared vector bus, zero when unclaimed |
| vec_valid_o | output | 1 | A slot has claimed the acknowledge |
| chain_po_o | output | NUM_SLOTS | Priority-out of each slot |

## Verification
A wrong pending flag shows up first on `irq_n_o`, on the same edge that should have set or cleared it. It shows up again as a wrong winner on the next acknowledge. A wrong snapshot or a broken link in the chain shows up in `chain_po_o`, `vec_o` and `vec_valid_o` one clock after the acknowledge rises. The bench compares all outputs against its model on every cycle, so a fault is reported within one clock of becoming observable.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;
  function automatic int unsigned slot_vector(input int unsigned base,
                                              input int unsigned stride,
                                              input int unsigned idx);
    return base + stride * idx;
  endfunction
endpackage

// File: rtl/irq_ack_edge.sv
module irq_ack_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ack_i,
  output logic ack_act_o,
  output logic ack_rise_o,
  output logic ack_fall_o
);
  logic ack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ack_q <= 1'b0;
    else         ack_q <= ack_i;
  end

  assign ack_act_o  = ack_q;
  assign ack_rise_o = ack_i & ~ack_q;
  assign ack_fall_o = ~ack_i & ack_q;
endmodule

// File: rtl/irq_slot.sv
module irq_slot #(
  parameter int unsigned VEC_W   = 8,
  parameter int unsigned VEC_VAL = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             ack_rise_i,
  input  logic             ack_fall_i,
  input  logic             pi_i,
  output logic             po_o,
  output logic             grant_o,
  output logic             pull_n_o,
  output logic [VEC_W-1:0] vec_o
);
  localparam logic [VEC_W-1:0] MyVec = VEC_W'(VEC_VAL);

  logic pend_q, snap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      snap_q <= 1'b0;
    end else begin
      // request beats clear on the same edge
      if (req_i)                      pend_q <= 1'b1;
      else if (ack_fall_i && grant_o) pend_q <= 1'b0;
      if (ack_rise_i)                 snap_q <= pend_q;
    end
  end

  assign grant_o  = pi_i & snap_q;
  assign po_o     = pi_i & ~snap_q;
  assign pull_n_o = ~pend_q;
  assign vec_o    = grant_o ? MyVec : '0;

  assert_pend_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !(ack_fall_i && grant_o)) |=> pend_q);

  assert_served_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_fall_i && grant_o && !req_i) |=> !pend_q);
endmodule

// File: rtl/irq_vec_mux.sv
module irq_vec_mux #(
  parameter int unsigned NUM_SLOTS = 4,
  parameter int unsigned VEC_W     = 8
) (
  input  logic [NUM_SLOTS-1:0][VEC_W-1:0] slot_vec_i,
  input  logic [NUM_SLOTS-1:0]            grant_i,
  output logic [VEC_W-1:0]                vec_o,
  output logic                            valid_o
);
  // slot vectors are pre-gated by grant, so OR is the bus
  logic [NUM_SLOTS:0][VEC_W-1:0] acc;
  assign acc[0] = '0;
  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_or
    assign acc[i+1] = acc[i] | slot_vec_i[i];
  end
  assign vec_o   = acc[NUM_SLOTS];
  assign valid_o = |grant_i;
endmodule

// File: rtl/irq_daisy_chain.sv
module irq_daisy_chain #(
  parameter int unsigned NUM_SLOTS  = 4,
  parameter int unsigned VEC_W      = 8,
  parameter int unsigned VEC_BASE   = 32'h20,
  parameter int unsigned VEC_STRIDE = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_SLOTS-1:0] dev_req_i,
  input  logic                 ack_i,
  output logic                 irq_n_o,
  output logic [VEC_W-1:0]     vec_o,
  output logic                 vec_valid_o,
  output logic [NUM_SLOTS-1:0] chain_po_o
);
  import irq_chain_pkg::*;

  logic ack_act, ack_rise, ack_fall;
  logic [NUM_SLOTS:0]            pi_chain;
  logic [NUM_SLOTS-1:0]          grant, pull_n;
  logic [NUM_SLOTS-1:0][VEC_W-1:0] slot_vec;

  irq_ack_edge u_edge (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ack_i     (ack_i),
    .ack_act_o (ack_act),
    .ack_rise_o(ack_rise),
    .ack_fall_o(ack_fall)
  );

  assign pi_chain[0] = ack_act;

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    irq_slot #(
      .VEC_W  (VEC_W),
      .VEC_VAL(slot_vector(VEC_BASE, VEC_STRIDE, i))
    ) u_slot (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .req_i     (dev_req_i[i]),
      .ack_rise_i(ack_rise),
      .ack_fall_i(ack_fall),
      .pi_i      (pi_chain[i]),
      .po_o      (pi_chain[i+1]),
      .grant_o   (grant[i]),
      .pull_n_o  (pull_n[i]),
      .vec_o     (slot_vec[i])
    );
  end

  irq_vec_mux #(.NUM_SLOTS(NUM_SLOTS), .VEC_W(VEC_W)) u_mux (
    .slot_vec_i(slot_vec),
    .grant_i   (grant),
    .vec_o     (vec_o),
    .valid_o   (vec_valid_o)
  );

  // open-drain line: any slot pulling low wins
  assign irq_n_o    = &pull_n;
  assign chain_po_o = pi_chain[NUM_SLOTS:1];

  assert_single_grant_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant));

  assert_claim_holds_line_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |-> !irq_n_o);

  assert_idle_bus_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_act |-> (!vec_valid_o && vec_o == '0 && chain_po_o == '0));

  assert_winner_frozen_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_act && ack_i) |=> $stable(grant));
endmodule

// File: tb/tb_irq_daisy_chain.sv
module tb_irq_daisy_chain;
  localparam int N = 4;
  localparam int VW = 8;
  localparam int VBASE = 'h20;
  localparam int VSTEP = 4;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] req = '0;
  logic ack = 0;
  logic irq_n, vvalid;
  logic [VW-1:0] vec;
  logic [N-1:0] po;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_daisy_chain #(.NUM_SLOTS(N), .VEC_W(VW), .VEC_BASE(VBASE), .VEC_STRIDE(VSTEP)) dut (
    .clk_i(clk), .rst_ni(rst_n), .dev_req_i(req), .ack_i(ack),
    .irq_n_o(irq_n), .vec_o(vec), .vec_valid_o(vvalid), .chain_po_o(po));

  // behavioural model
  logic [N-1:0] mpend = '0, msnap = '0;
  logic mack = 0;

  function automatic int winner();
    if (!mack) return -1;
    for (int i = 0; i < N; i++) if (msnap[i]) return i;
    return -1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mpend <= '0; msnap <= '0; mack <= 0;
    end else begin
      automatic int w = winner();
      automatic logic [N-1:0] np = mpend;
      if (!ack && mack && w >= 0) np[w] = 1'b0;
      np = np | req;
      if (ack && !mack) msnap <= mpend;
      mpend <= np;
      mack <= ack;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    automatic int w = winner();
    automatic logic [N-1:0] epo = '0;
    automatic int ev = (w >= 0) ? VBASE + VSTEP * w : 0;
    automatic string ptag = !mack ? "R7" : (w < 0 ? "R6" : "R5");
    automatic string vtag = !mack ? "R7" : (w < 0 ? "R6" : "R4");
    if (mack) for (int i = 0; i < N; i++) epo[i] = (w < 0) || (i < w);
    chk(irq_n == (mpend == '0), "R2 irq_n", irq_n, mpend == '0);
    chk(po == epo, {ptag, " chain_po"}, po, epo);
    chk(vec == VW'(ev), {vtag, " vec"}, vec, ev);
    chk(vvalid == (w >= 0), {vtag, " valid"}, vvalid, w >= 0);
  endtask

  task automatic step(input logic [N-1:0] r, input logic a);
    req = r; ack = a;
    @(posedge clk); @(negedge clk);
    compare();
  endtask

  task automatic serve_expect(input int slot, input string tag);
    ack = 1; #1;
    chk(vvalid == 0, "R10 valid before edge", vvalid, 0);
    step('0, 1);
    chk(vec == VW'(VBASE + VSTEP * slot), {tag, " served vector"}, vec, VBASE + VSTEP * slot);
    step('0, 1);
    step('0, 0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    compare();
    chk(irq_n == 1 && vvalid == 0 && vec == 0, "R2 reset state", {irq_n, vvalid}, 2'b10);
    rst_n = 1;
    @(negedge clk); compare();

    // each slot alone: vector map
    for (int s = 0; s < N; s++) begin
      step(N'(1) << s, 0);
      step('0, 0);
      chk(irq_n == 0, "R3 pending held after req drop", irq_n, 0);
      serve_expect(s, "R1");
      chk(irq_n == 1, "R9 line released", irq_n, 1);
    end

    // ack with nothing pending
    step('0, 1);
    chk(po == '1 && vvalid == 0, "R6 pass-through", po, 4'hf);
    step('0, 0);

    // two pending: 1 and 3
    step(4'b1010, 0);
    step('0, 0);
    serve_expect(1, "R4");
    chk(irq_n == 0, "R9 slot3 still pending", irq_n, 0);
    serve_expect(3, "R4");
    chk(irq_n == 1, "R9 all served", irq_n, 1);

    // request arriving mid-acknowledge
    step(4'b0100, 0);
    step('0, 1);
    step(4'b0001, 1);
    step('0, 1);
    chk(vec == VW'(VBASE + 2 * VSTEP), "R8 winner kept", vec, VBASE + 2 * VSTEP);
    step('0, 0);
    chk(irq_n == 0, "R8 late request pending", irq_n, 0);
    serve_expect(0, "R8");

    // re-request on the clearing edge
    step(4'b0010, 0);
    step('0, 1);
    step(4'b0010, 0);
    chk(irq_n == 0, "R9 re-request survives clear", irq_n, 0);
    serve_expect(1, "R9");
    chk(irq_n == 1, "R9 released", irq_n, 1);

    // all pending, drain in order
    step(4'b1111, 0);
    for (int s = 0; s < N; s++) serve_expect(s, "R5");
    chk(irq_n == 1, "R2 drained", irq_n, 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule